// File: doc/BRIEF.md
# Charging Port Mode Controller

This block picks the battery-charging mode of every downstream port of a hub and drives the power-enable signal for each port's external power switch. For each port, a charge-enable bit, the VBUS-above-4-V comparator flag and one global bit that disables automatic mode together choose among five modes. In automatic mode, a per-port hint from the attach-detection circuit chooses between a voltage-divider advertisement and a dedicated-charger presentation. The divider advertises either the high-current level or the legacy level.

Every change of a port's mode forces a power-off interval on that port. The interval lasts a programmable number of coarse time units, and each unit is one pulse of an external tick. The enable outputs can be active-high or active-low. They can drive each port on its own, or all ports together. An overcurrent input forces the port's enable to its inactive level at once and sets a sticky flag, which software clears.

Top module: `chgport_mode_ctrl`

## Requirements
- R1: During and after reset every port reports mode 0, every hold-off counter is empty (so each port counts as powered), and every overcurrent flag is 0.
- R2: A port whose charge-enable bit is 0 reports mode 0 (off), whatever the other inputs are.
- R3: A charge-enabled port reports mode 4 (charging downstream port) while `vbus_hi` is 1, whatever `auto_dis` is.
- R4: A charge-enabled port with `vbus_hi` 0 and `auto_dis` 0 reports mode 1 (auto, divider) when its `dcp_pref` bit is 0 and mode 2 (auto, dedicated charger) when it is 1.
- R5: A charge-enabled port with `vbus_hi` 0 and `auto_dis` 1 reports mode 3 (dedicated charger only).
- R6: `div_hi[i]` is 1 exactly when port i is in mode 1 and `hicur_en` is 1. A value of 1 means the 10 W level and 0 means the 5 W level.
- R7: The mode output is registered. It takes its new value at the first rising clock edge after an input changes.
- R8: When a port's mode changes, that port's power is off until it has seen `pwron_dly`+1 tick pulses. It is on in the cycle after the clock edge that takes the last of those pulses. This holds for `pwron_dly` from 0 to 7.
- R9: A mode change during a hold-off restarts the full interval. A tick pulse that arrives in the same cycle as a change does not count.
- R10: While `oc[i]` is 1, the enable of port i is at its inactive level in the same cycle. In ganged mode this applies to every port.
- R11: `oc_flag[i]` sets on the clock edge after `oc[i]` is seen high. It then stays at 1 until an edge at which `oc_clr[i]` is 1 and `oc[i]` is 0. If both are 1 at the same edge, the flag stays set.
- R12: With `pol_hi` 1 an active port drives `pwr_en` 1. With `pol_hi` 0 an active port drives 0.
- R13: With `gang_en` 1 every `pwr_en` bit carries the same value. That value is active only when every port is out of hold-off and free of overcurrent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per hold-off time unit |
| chg_en | input | NPORTS | Per-port charge enable |
| vbus_hi | input | 1 | Upstream VBUS above 4 V |
| auto_dis | input | 1 | 1 disables automatic mode |
| hicur_en | input | 1 | Divider advertises high current when 1 |
| dcp_pref | input | NPORTS | Detection hint: in auto mode, use dedicated-charger presentation |
| gang_en | input | 1 | One shared enable for all ports |
| pol_hi | input | 1 | Enable polarity: 1 active high, 0 active low |
| pwron_dly | input | DLY_W | Hold-off length minus one, in ticks |
| oc | input | NPORTS | Per-port overcurrent |
| oc_clr | input | NPORTS | Per-port clear of the sticky overcurrent flag |
| mode_o | output | NPORTS*3 | Mode code of port i in bits [3i+2:3i] |
| div_hi | output | NPORTS | Divider level per port |
| pwr_en | output | NPORTS | Power-switch enable per port |
| oc_flag | output | NPORTS | Sticky overcurrent flag per port |

## Verification
Two pairs of events can fall in the same cycle. A mode change can land on the same edge as a tick pulse, so the reload of the hold-off counter competes with its decrement. An overcurrent can be present on the same edge as a software clear, so the set of the sticky flag competes with its clear. The bench drives each pair together on purpose and checks that the reload wins (a full set of further ticks is needed) and that the set wins (the flag stays at 1). A long random phase with frequent ticks and short delays hits both pairs many more times, and a behavioural model judges every cycle.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      CPM_OFF      = 3'd0,
      CPM_AUTO_DIV = 3'd1,
      CPM_AUTO_DCP = 3'd2,
      CPM_DCP      = 3'd3,
      CPM_CDP      = 3'd4
   } cpm_mode_e;

   function automatic cpm_mode_e cpm_pick_mode(input logic en, input logic vbus,
                                               input logic adis, input logic pref);
      cpm_mode_e m;
      if (!en)        m = CPM_OFF;
      else if (vbus)  m = CPM_CDP;
      else if (!adis) m = pref ? CPM_AUTO_DCP : CPM_AUTO_DIV;
      else            m = CPM_DCP;
      return m;
   endfunction

endpackage

// File: rtl/cpm_mode_sel.sv
module cpm_mode_sel
   import cpm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      chg_en,
   input  logic      vbus_hi,
   input  logic      auto_dis,
   input  logic      dcp_pref,
   input  logic      hicur_en,
   output cpm_mode_e mode_q,
   output logic      mode_chg,
   output logic      div_hi
);

   cpm_mode_e mode_nxt;

   always_comb begin
      mode_nxt = cpm_pick_mode(chg_en, vbus_hi, auto_dis, dcp_pref);
      mode_chg = (mode_nxt != mode_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= CPM_OFF;
      else        mode_q <= mode_nxt;
   end

   assign div_hi = (mode_q == CPM_AUTO_DIV) && hicur_en;

   // R2: a disabled port is off one edge later
   p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_en |=> (mode_q == CPM_OFF));

   // R3: VBUS present wins over the auto-mode bit
   p_cdp_on_vbus_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_en && vbus_hi) |=> (mode_q == CPM_CDP));

   p_legal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q <= CPM_CDP);

endmodule

// File: rtl/cpm_holdoff.sv
module cpm_holdoff #(
   parameter int DLY_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reload,
   input  logic [DLY_W-1:0] dly,
   output logic             ready
);

   localparam int CNT_W = DLY_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << DLY_W;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_val;

   assign load_val = {1'b0, dly} + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (reload)                cnt <= load_val;
      else if (tick && cnt != '0)     cnt <= cnt - CNT_W'(1);
   end

   assign ready = (cnt == '0);

   // R8: a mode change always leaves the port held off
   p_hold_after_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> !ready);

   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);

   // R9: without a tick or a change the count is frozen
   p_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !tick) |=> $stable(cnt));

endmodule

// File: rtl/cpm_pwr_out.sv
module cpm_pwr_out #(
   parameter int NPORTS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] ready,
   input  logic [NPORTS-1:0] oc,
   input  logic [NPORTS-1:0] oc_clr,
   input  logic              gang_en,
   input  logic              pol_hi,
   output logic [NPORTS-1:0] pwr_en,
   output logic [NPORTS-1:0] oc_flag
);

   logic [NPORTS-1:0] port_on;
   logic [NPORTS-1:0] act;
   logic              all_on;

   assign port_on = ready & ~oc;
   assign all_on  = &port_on;

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      always_comb begin
         act[i]    = gang_en ? all_on : port_on[i];
         pwr_en[i] = pol_hi ? act[i] : ~act[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         oc_flag[i] <= 1'b0;
         else if (oc[i])     oc_flag[i] <= 1'b1;
         else if (oc_clr[i]) oc_flag[i] <= 1'b0;
      end

      // R10: overcurrent forces the inactive level at the pin
      p_oc_forces_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
         oc[i] |-> (pwr_en[i] == ~pol_hi));

      // R11: overcurrent always leaves the flag set
      p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
         oc[i] |=> oc_flag[i]);
   end

   // R13: ganged outputs never disagree
   p_gang_uniform_r13: assert property (@(posedge clk) disable iff (!rst_n)
      gang_en |-> (pwr_en == {NPORTS{1'b0}} || pwr_en == {NPORTS{1'b1}}));

endmodule

// File: rtl/chgport_mode_ctrl.sv
module chgport_mode_ctrl
   import cpm_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int DLY_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic [NPORTS-1:0]        chg_en,
   input  logic                     vbus_hi,
   input  logic                     auto_dis,
   input  logic                     hicur_en,
   input  logic [NPORTS-1:0]        dcp_pref,
   input  logic                     gang_en,
   input  logic                     pol_hi,
   input  logic [DLY_W-1:0]         pwron_dly,
   input  logic [NPORTS-1:0]        oc,
   input  logic [NPORTS-1:0]        oc_clr,
   output logic [NPORTS*MODE_W-1:0] mode_o,
   output logic [NPORTS-1:0]        div_hi,
   output logic [NPORTS-1:0]        pwr_en,
   output logic [NPORTS-1:0]        oc_flag
);

   if (NPORTS < 1 || NPORTS > 16) begin : g_bad_ports
      $error("chgport_mode_ctrl: NPORTS out of range");
   end
   if (DLY_W < 1 || DLY_W > 8) begin : g_bad_dly
      $error("chgport_mode_ctrl: DLY_W out of range");
   end

   logic [NPORTS-1:0] mode_chg;
   logic [NPORTS-1:0] ready;

   for (genvar i = 0; i < NPORTS; i++) begin : g_ch
      cpm_mode_e m;

      cpm_mode_sel u_sel (
         .clk      (clk),
         .rst_n    (rst_n),
         .chg_en   (chg_en[i]),
         .vbus_hi  (vbus_hi),
         .auto_dis (auto_dis),
         .dcp_pref (dcp_pref[i]),
         .hicur_en (hicur_en),
         .mode_q   (m),
         .mode_chg (mode_chg[i]),
         .div_hi   (div_hi[i])
      );

      cpm_holdoff #(.DLY_W(DLY_W)) u_hold (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .reload (mode_chg[i]),
         .dly    (pwron_dly),
         .ready  (ready[i])
      );

      assign mode_o[i*MODE_W +: MODE_W] = m;
   end

   cpm_pwr_out #(.NPORTS(NPORTS)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready   (ready),
      .oc      (oc),
      .oc_clr  (oc_clr),
      .gang_en (gang_en),
      .pol_hi  (pol_hi),
      .pwr_en  (pwr_en),
      .oc_flag (oc_flag)
   );

   // R12: a port out of hold-off and free of overcurrent shows the active level
   p_active_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!gang_en && ready[0] && !oc[0]) |-> (pwr_en[0] == pol_hi));

endmodule

// File: tb/chgport_mode_ctrl_test.sv
`timescale 1ns/100ps
module chgport_mode_ctrl_test;

   localparam int N  = 4;
   localparam int DW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic [N-1:0] chg_en = '0;
   logic vbus_hi = 1'b0;
   logic auto_dis = 1'b0;
   logic hicur_en = 1'b0;
   logic [N-1:0] dcp_pref = '0;
   logic gang_en = 1'b0;
   logic pol_hi = 1'b1;
   logic [DW-1:0] pwron_dly = 3'd2;
   logic [N-1:0] oc = '0;
   logic [N-1:0] oc_clr = '0;
   logic [N*3-1:0] mode_o;
   logic [N-1:0] div_hi, pwr_en, oc_flag;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   int mmode [N];
   int mcnt  [N];
   int mflag [N];

   chgport_mode_ctrl #(.NPORTS(N), .DLY_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .chg_en(chg_en), .vbus_hi(vbus_hi),
      .auto_dis(auto_dis), .hicur_en(hicur_en), .dcp_pref(dcp_pref), .gang_en(gang_en),
      .pol_hi(pol_hi), .pwron_dly(pwron_dly), .oc(oc), .oc_clr(oc_clr),
      .mode_o(mode_o), .div_hi(div_hi), .pwr_en(pwr_en), .oc_flag(oc_flag)
   );

   always #2.5 clk = ~clk;

   initial begin
      for (int i = 0; i < N; i++) begin
         mmode[i] = 0; mcnt[i] = 0; mflag[i] = 0;
      end
   end

   function automatic int want_mode(int i);
      if (!chg_en[i]) return 0;
      if (vbus_hi)    return 4;
      if (!auto_dis)  return dcp_pref[i] ? 2 : 1;
      return 3;
   endfunction

   function automatic int want_pwr(int i);
      int all, act, mine;
      all = 1;
      for (int k = 0; k < N; k++) if (mcnt[k] != 0 || oc[k]) all = 0;
      mine = (mcnt[i] == 0 && !oc[i]) ? 1 : 0;
      act  = gang_en ? all : mine;
      return pol_hi ? act : 1 - act;
   endfunction

   always @(posedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (!rst_n) begin
            mmode[i] = 0; mcnt[i] = 0; mflag[i] = 0;
         end else begin
            int nm;
            nm = want_mode(i);
            if (nm != mmode[i]) mcnt[i] = pwron_dly + 1;
            else if (tick && mcnt[i] > 0) mcnt[i] = mcnt[i] - 1;
            mmode[i] = nm;
            if (oc[i]) mflag[i] = 1;
            else if (oc_clr[i]) mflag[i] = 0;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         for (int i = 0; i < N; i++) begin
            int dh;
            dh = (mmode[i] == 1 && hicur_en) ? 1 : 0;
            check(int'(mode_o[i*3 +: 3]) == mmode[i], "R7 model mode", int'(mode_o[i*3 +: 3]), mmode[i]);
            check(int'(div_hi[i]) == dh, "R6 model divider", int'(div_hi[i]), dh);
            check(int'(pwr_en[i]) == want_pwr(i), "R8/R12/R13 model power", int'(pwr_en[i]), want_pwr(i));
            check(int'(oc_flag[i]) == mflag[i], "R11 model flag", int'(oc_flag[i]), mflag[i]);
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic pulse();
      tick = 1'b1; step(); tick = 1'b0;
   endtask

   function automatic int md(int i);
      return int'(mode_o[i*3 +: 3]);
   endfunction

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) step();
      // R1: reset state
      for (int i = 0; i < N; i++) begin
         check(md(i) == 0, "R1 mode", md(i), 0);
         check(pwr_en[i] == 1'b1, "R1 power", int'(pwr_en[i]), 1);
         check(oc_flag[i] == 1'b0, "R1 flag", int'(oc_flag[i]), 0);
      end
      rst_n = 1'b1;
      step();

      // R4 / R7: enable port 0 in auto divider mode
      chg_en = 4'b0001;
      #1;
      check(md(0) == 0, "R7 before edge", md(0), 0);
      step();
      check(md(0) == 1, "R4 divider", md(0), 1);
      check(div_hi[0] == 1'b0, "R6 legacy level", int'(div_hi[0]), 0);
      check(pwr_en[0] == 1'b0, "R8 held", int'(pwr_en[0]), 0);
      pulse(); pulse();
      check(pwr_en[0] == 1'b0, "R8 after two ticks", int'(pwr_en[0]), 0);
      pulse();
      check(pwr_en[0] == 1'b1, "R8 after three ticks", int'(pwr_en[0]), 1);

      hicur_en = 1'b1; step();
      check(div_hi[0] == 1'b1, "R6 high level", int'(div_hi[0]), 1);
      dcp_pref[0] = 1'b1; step();
      check(md(0) == 2, "R4 auto dcp", md(0), 2);
      check(div_hi[0] == 1'b0, "R6 not divider", int'(div_hi[0]), 0);
      auto_dis = 1'b1; step();
      check(md(0) == 3, "R5 dcp only", md(0), 3);
      vbus_hi = 1'b1; step();
      check(md(0) == 4, "R3 cdp", md(0), 4);
      auto_dis = 1'b0; step();
      check(md(0) == 4, "R3 auto bit ignored", md(0), 4);
      chg_en = 4'b0000; step();
      check(md(0) == 0, "R2 disabled", md(0), 0);
      vbus_hi = 1'b0; auto_dis = 1'b1; step();
      check(md(0) == 0, "R2 still off", md(0), 0);

      // R9: change together with a tick restarts the interval
      auto_dis = 1'b0; dcp_pref[0] = 1'b0;
      chg_en = 4'b0001; step();
      pulse();
      dcp_pref[0] = 1'b1; tick = 1'b1; step(); tick = 1'b0;
      pulse(); pulse();
      check(pwr_en[0] == 1'b0, "R9 restart held", int'(pwr_en[0]), 0);
      pulse();
      check(pwr_en[0] == 1'b1, "R9 restart done", int'(pwr_en[0]), 1);

      // R10 / R11: overcurrent and sticky flag, set beats clear
      oc[1] = 1'b1; #1;
      check(pwr_en[1] == 1'b0, "R10 forced off", int'(pwr_en[1]), 0);
      step();
      check(oc_flag[1] == 1'b1, "R11 set", int'(oc_flag[1]), 1);
      oc_clr[1] = 1'b1; step();
      check(oc_flag[1] == 1'b1, "R11 set wins", int'(oc_flag[1]), 1);
      oc[1] = 1'b0; step();
      check(oc_flag[1] == 1'b0, "R11 cleared", int'(oc_flag[1]), 0);
      oc_clr[1] = 1'b0; step();
      check(pwr_en[1] == 1'b1, "R10 released", int'(pwr_en[1]), 1);

      // R12: active low
      pol_hi = 1'b0; #1;
      check(pwr_en[2] == 1'b0, "R12 active low", int'(pwr_en[2]), 0);

      // R13: ganged, one port held off
      gang_en = 1'b1; dcp_pref[0] = 1'b0; step();
      check(pwr_en == 4'b1111, "R13 all inactive", int'(pwr_en), 15);
      pulse(); pulse(); pulse();
      check(pwr_en == 4'b0000, "R13 all active", int'(pwr_en), 0);
      oc[3] = 1'b1; #1;
      check(pwr_en == 4'b1111, "R10 ganged overcurrent", int'(pwr_en), 15);
      oc[3] = 1'b0; oc_clr[3] = 1'b1; step(); oc_clr[3] = 1'b0;
      gang_en = 1'b0; pol_hi = 1'b1;

      // R8 boundaries: delay 0 and 7
      pwron_dly = 3'd0; dcp_pref[0] = 1'b1; step();
      check(pwr_en[0] == 1'b0, "R8 zero held", int'(pwr_en[0]), 0);
      pulse();
      check(pwr_en[0] == 1'b1, "R8 zero done", int'(pwr_en[0]), 1);
      pwron_dly = 3'd7; dcp_pref[0] = 1'b0; step();
      for (int k = 0; k < 7; k++) pulse();
      check(pwr_en[0] == 1'b0, "R8 max held", int'(pwr_en[0]), 0);
      pulse();
      check(pwr_en[0] == 1'b1, "R8 max done", int'(pwr_en[0]), 1);

      // random phase, judged by the model every cycle
      for (int c = 0; c < 3000; c++) begin
         tick     = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 7) == 0) chg_en = N'($urandom);
         if ($urandom_range(0, 9) == 0) vbus_hi = $urandom_range(0, 1);
         if ($urandom_range(0, 9) == 0) auto_dis = $urandom_range(0, 1);
         if ($urandom_range(0, 5) == 0) dcp_pref = N'($urandom);
         if ($urandom_range(0, 9) == 0) hicur_en = $urandom_range(0, 1);
         if ($urandom_range(0, 19) == 0) gang_en = $urandom_range(0, 1);
         if ($urandom_range(0, 19) == 0) pol_hi = $urandom_range(0, 1);
         if ($urandom_range(0, 15) == 0) pwron_dly = DW'($urandom_range(0, 3));
         oc     = ($urandom_range(0, 7) == 0) ? N'($urandom) : '0;
         oc_clr = N'($urandom);
         step();
      end

      tick = 1'b0;
      step();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule